// File: doc/BRIEF.md
# Serial Bit-Addressed Bus Master

This block is the controller end of a synchronous I/O bus that carries one data bit at a time. Each bit travels alongside a 12-bit parallel bit address. A requester issues one start command with a 16-bit base register value, a bit count and, for writes, a data word. The block then runs that many bit transfers back to back. It puts the bit address on the address lines and the outgoing bit on a dedicated output line, then pulses a one-cycle clock strobe. On reads, it samples a separate input line during the strobe.

The starting bit address is half the base register value, and it steps up by one after every strobe. A single command therefore moves a string of up to 16 consecutive bits. Read bits are gathered into a result word at their bit positions, and a one-cycle done pulse marks completion. A busy flag covers the whole transfer, and starts that arrive while it is high are dropped.

Top module: `sbus_master`

## Requirements
- R1: On an accepted start, the bit address becomes bits 12 down to 1 of `cmd_base` (the value shifted right by one). Bit 0 and bits 15 to 13 have no effect on it.
- R2: Each bit takes exactly two cycles: one setup cycle with the strobe low, then one cycle with the strobe high. The strobe is never high in two consecutive cycles.
- R3: The bit address holds its value through a bit's setup and strobe cycles. It increases by one in the cycle after each strobe.
- R4: Address arithmetic is modulo 4096, so address 0xFFF is followed by 0x000.
- R5: A `cmd_count` of 1 to 15 produces that many strobes. A `cmd_count` of 0 produces 16 strobes.
- R6: In a write, bit i of `cmd_wdata` is on `bus_dout` during the setup and strobe cycles of the i-th bit, counting from bit 0 (least significant bit first).
- R7: In a read, `bus_din` is sampled at the end of the i-th strobe cycle and stored in bit i of `rdata`. All bits of `rdata` are cleared when the read is accepted, and `bus_dout` stays low throughout.
- R8: `busy` is high from the cycle after acceptance until the last strobe cycle ends. A start that arrives while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle, the cycle after the last strobe, and `rdata` holds the final result at that point. A write does not change `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start request, accepted only while not busy |
| cmd_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cmd_base | input | 16 | Base register value; bit address is bits 12:1 |
| cmd_count | input | 4 | Number of bits, 0 means 16 |
| cmd_wdata | input | 16 | Write data, bit 0 sent first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Packed read result |
| bus_addr | output | 12 | Bit address lines |
| bus_dout | output | 1 | Data towards the devices |
| bus_strobe | output | 1 | Bit clock strobe, one cycle high per bit |
| bus_din | input | 1 | Data from the devices |

## Verification
The assertions assume that the command inputs are sampled only at a clock edge and that `cmd_base` holds a defined value whenever `cmd_start` is high. They do not assume that a requester waits for `busy` to drop. The stimulus changes inputs only on the falling edge, which keeps it within these limits. It deliberately raises `cmd_start` in the middle of transfers to exercise the drop rule. `bus_din` is produced by a fixed function of the address lines, so the value that is sampled depends only on which address the strobe reached.

// File: rtl/sbus_pkg.sv
// Package: shared types for the serial bit-addressed bus master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sbus_pkg;

    // Sequencer phases: waiting, address/data setup, strobe high.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } sbus_phase_e;

endpackage

// File: rtl/sbus_seq.sv
// Module: sbus_seq
// Sequences one command into per-bit setup and strobe cycles, tracks the
// bit index and signals completion. Assumes start is only honoured in idle.
module sbus_seq
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_write,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             load,
    output logic             advance,
    output logic             strobe,
    output logic             busy,
    output logic             done,
    output logic             is_write,
    output logic [CNT_W-1:0] idx
);

    sbus_phase_e      phase_q;
    logic [CNT_W-1:0] last_q;
    logic             done_q;

    // Accept decode and phase-derived controls.
    always_comb begin
        load    = start && (phase_q == PH_IDLE);
        advance = (phase_q == PH_STROBE);
        strobe  = (phase_q == PH_STROBE);
        busy    = (phase_q != PH_IDLE);
        done    = done_q;
    end

    // Phase register: idle -> setup -> strobe -> setup ... -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   if (load) phase_q <= PH_SETUP;
                PH_SETUP:  phase_q <= PH_STROBE;
                PH_STROBE: phase_q <= (idx == last_q) ? PH_IDLE : PH_SETUP;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Bit index, final index (count minus one, wrapping 0 to all ones) and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            last_q   <= '0;
            is_write <= 1'b0;
        end else if (load) begin
            idx      <= '0;
            last_q   <= cmd_count - 1'b1;
            is_write <= cmd_write;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    // Completion pulse in the cycle after the final strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= advance && (idx == last_q);
    end

endmodule

// File: rtl/sbus_addr_ctr.sv
// Module: sbus_addr_ctr
// Holds the bit address: loads base>>1 on accept, steps by one after each
// strobe, wrapping at 2**ADDR_W. Assumes BASE_W > ADDR_W.
module sbus_addr_ctr #(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [BASE_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);

    // Address register with load and natural-width increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (load)    addr <= base[ADDR_W:1];
        else if (advance) addr <= addr + 1'b1;
    end

endmodule

// File: rtl/sbus_data_path.sv
// Module: sbus_data_path
// Captures write data and drives the selected bit; packs sampled read bits
// at their index. Assumes idx stays below DATA_W.
module sbus_data_path #(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic              advance,
    input  logic              busy,
    input  logic              is_write,
    input  logic [CNT_W-1:0]  idx,
    input  logic              din,
    output logic              dout,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] wdata_q;

    // Write word capture.
    always_ff @(posedge clk) begin
        if (!rst_n)    wdata_q <= '0;
        else if (load) wdata_q <= wdata;
    end

    // Outgoing bit: selected write bit while a write runs, low otherwise.
    always_comb begin
        dout = busy && is_write && wdata_q[idx];
    end

    // Read result: cleared on read accept, filled at each strobe end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (load && !cmd_write) begin
            rdata <= '0;
        end else if (advance && !is_write) begin
            rdata[idx] <= din;
        end
    end

endmodule

// File: rtl/sbus_master.sv
// Module: sbus_master (top)
// Master side of a one-bit serial bus with a parallel bit address. One
// command moves 1..DATA_W consecutive bits. Assumes synchronous inputs.
module sbus_master #(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 16,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [BASE_W-1:0] cmd_base,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dout,
    output logic              bus_strobe,
    input  logic              bus_din
);

    logic             load;
    logic             advance;
    logic             is_write;
    logic [CNT_W-1:0] idx;

    sbus_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .cmd_write (cmd_write),
        .cmd_count (cmd_count),
        .load      (load),
        .advance   (advance),
        .strobe    (bus_strobe),
        .busy      (busy),
        .done      (done),
        .is_write  (is_write),
        .idx       (idx)
    );

    sbus_addr_ctr #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .base    (cmd_base),
        .addr    (bus_addr)
    );

    sbus_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cmd_write (cmd_write),
        .wdata     (cmd_wdata),
        .advance   (advance),
        .busy      (busy),
        .is_write  (is_write),
        .idx       (idx),
        .din       (bus_din),
        .dout      (bus_dout),
        .rdata     (rdata)
    );

endmodule

// File: rtl/sbus_master_chk.sv
// Module: sbus_master_chk
// Protocol checks on the top-level ports, attached by bind.
module sbus_master_chk #(
    parameter int ADDR_W = 12,
    parameter int BASE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [BASE_W-1:0] cmd_base,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_dout,
    input logic              bus_strobe
);

    // R2: strobe never high two cycles running
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);

    // R3: address held from setup into strobe
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> $stable(bus_addr));

    // R3, R4: address steps by one (mod 2**ADDR_W) after each strobe
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1)));

    // R6: outgoing bit stable between setup and strobe
    a_r6_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> $stable(bus_dout));

    // R1: accepted start loads base shifted right by one
    a_r1_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> (busy && bus_addr == $past(cmd_base[ADDR_W:1])));

    // R8: start during setup does not disturb the address
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_strobe && cmd_start) |=> $stable(bus_addr));

    // R9: done is one cycle and only outside busy
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

endmodule

bind sbus_master sbus_master_chk #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_base   (cmd_base),
    .busy       (busy),
    .done       (done),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_strobe (bus_strobe)
);

// File: tb/sbus_master_tb.sv
// Bench: behavioural per-cycle reference model compared on every falling edge.
module sbus_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_base = '0;
    logic [3:0]  cmd_count = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, bus_dout, bus_strobe, bus_din;
    logic [15:0] rdata;
    logic [11:0] bus_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int strobes = 0;

    // Reference model state
    int m_phase = 0;
    int m_addr = 0;
    int m_bit = 0;
    int m_len = 0;
    bit m_write = 0;
    bit [15:0] m_wdata = 0;
    bit [15:0] m_rdata = 0;
    bit m_done = 0;

    always #5 clk = ~clk;

    sbus_master u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_write (cmd_write),
        .cmd_base (cmd_base), .cmd_count (cmd_count), .cmd_wdata (cmd_wdata),
        .busy (busy), .done (done), .rdata (rdata), .bus_addr (bus_addr),
        .bus_dout (bus_dout), .bus_strobe (bus_strobe), .bus_din (bus_din)
    );

    function automatic bit dev_bit(input int a);
        return a[0] ^ a[2] ^ a[5] ^ a[11];
    endfunction

    assign bus_din = dev_bit(int'(bus_addr));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Model update on the rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_bit = 0; m_done = 0; m_rdata = 0; m_write = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (cmd_start) begin
                    m_phase = 1;
                    m_addr  = (int'(cmd_base) / 2) % 4096;
                    m_write = cmd_write;
                    m_wdata = cmd_wdata;
                    m_len   = (cmd_count == 0) ? 16 : int'(cmd_count);
                    m_bit   = 0;
                    if (!cmd_write) m_rdata = 0;
                end
                1: m_phase = 2;
                default: begin
                    strobes++;
                    if (!m_write) m_rdata[m_bit] = dev_bit(m_addr);
                    m_addr = (m_addr + 1) % 4096;
                    m_bit++;
                    if (m_bit == m_len) begin m_phase = 0; m_done = 1; end
                    else m_phase = 1;
                end
            endcase
        end
    end

    // Compare all outputs on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 addr", int'(bus_addr), m_addr);
            check("R2 strobe", int'(bus_strobe), int'(m_phase == 2));
            check("R6/R7 dout", int'(bus_dout), int'(m_phase != 0 && m_write && m_wdata[m_bit]));
            check("R8 busy", int'(busy), int'(m_phase != 0));
            check("R9 done", int'(done), int'(m_done));
            check("R7/R9 rdata", int'(rdata), int'(m_rdata));
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 100000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_cmd(input bit wr, input logic [15:0] base, input logic [3:0] cnt,
                           input logic [15:0] wd, input bool_poke);
        int exp_len;
        exp_len = (cnt == 0) ? 16 : int'(cnt);
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = wr; cmd_base = base; cmd_count = cnt; cmd_wdata = wd;
        strobes = 0;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R1 start addr", int'(bus_addr), int'(base[12:1]));
        if (bool_poke) begin
            // R8: a start during busy must be dropped
            cmd_start = 1'b1; cmd_base = 16'h5A5A; cmd_write = ~wr;
            @(negedge clk);
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (!done) @(negedge clk);
        check("R5 strobe count", strobes, exp_len);
        check("R9 done rdata", int'(rdata), int'(m_rdata));
        @(negedge clk);
        check("R9 done single", int'(done), 0);
    endtask

    typedef bit bool_t;
    localparam bool_t bool_poke_default = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset busy", int'(busy), 0);
        check("R2 reset strobe", int'(bus_strobe), 0);
        check("R9 reset rdata", int'(rdata), 0);
        rst_n = 1'b1;
        run_cmd(1'b1, 16'h1300, 4'd1, 16'h0001, 1'b0);
        run_cmd(1'b0, 16'h1300, 4'd8, 16'h0000, 1'b0);
        run_cmd(1'b1, 16'hE_0_0_3 & 16'hFFFF, 4'd5, 16'hA5C3, 1'b0);   // R1 high and low bits ignored
        run_cmd(1'b0, 16'h1FFA, 4'd0, 16'h0000, 1'b0);               // R4 wrap with 16 bits
        check("R4 wrapped addr", int'(bus_addr), 16'h1FFA / 2 + 16 - 4096);
        run_cmd(1'b1, 16'h0800, 4'd0, 16'hBEEF, 1'b0);               // R6 16-bit write, R9 rdata kept
        check("R9 write keeps rdata", int'(rdata), int'(m_rdata));
        run_cmd(1'b0, 16'h0F00, 4'd15, 16'h0000, 1'b1);              // R8 ignored start
        run_cmd(1'b1, 16'h2700, 4'd3, 16'h0006, 1'b1);
        run_cmd(1'b0, 16'h0000, 4'd2, 16'h0000, 1'b0);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule